// File: doc/BRIEF.md
# Pin Sense Detect Latch

This block watches a bank of input pins. Each pin has a two-bit sense setting that turns sensing off or looks for a high or a low level. Every pin produces a registered live detect. A sticky latch word keeps every pin hit until software removes it by writing ones. The latch cannot be cleared while the pin's live detect is still asserted. A latched-detect output is high while any latch bit is set. After every clear write it drops for one cycle, so a consumer sees a new rising edge whenever hits remain.

A mode bit chooses the source of the port-level detect output. It is either the OR of all live pin detects or the latched-detect signal. A one-cycle event pulse marks every 0-to-1 transition of that output. Software reaches the configuration, the latch, the mode bit and the live detects through a write strobe and a registered read port.

Top module: `pin_sense_latch`

## Requirements
- R1: Pin n is configured by the two-bit field at bits [2*(n%16)+1 : 2*(n%16)] of configuration word n/16 (addresses 0 and 1). 2'b00 disables sensing and 2'b01 is reserved and also disables it. 2'b10 detects a high pin and 2'b11 detects a low pin. `pin_det_o[n]` is the registered result, valid one cycle after the pin or field changes.
- R2: While `pin_det_o[n]` is high, bit n of the latch word (address 2) is 1 from the following cycle on.
- R3: A latch bit stays 1 after its pin detect falls, and it remains readable at address 2.
- R4: Writing address 2 clears, in the next cycle, each latch bit whose data bit is 1 and whose pin detect is low. Bits whose detect is high are not cleared, and bits written with 0 are left unchanged.
- R5: Outside the cycle after a latch write, `latch_det_o` equals the OR of the latch word of the previous cycle. It goes low once all latch bits are cleared.
- R6: Any write to address 2 drives `latch_det_o` low for exactly the next cycle. After that cycle it returns high if any latch bit is still set.
- R7: Mode bit 0 at address 3 selects the source of `port_det_o`, registered one cycle. With the bit at 0 the source is the OR of all pin detects. With the bit at 1 the source is `latch_det_o`.
- R8: `port_evt_o` is high for one cycle, the first cycle of each 0-to-1 transition of `port_det_o`, and it is low at all other times.
- R9: Enabling a sense field whose condition already holds raises the pin detect on the next cycle. In mode 0 this raises `port_det_o` and `port_evt_o` one cycle later when the port detect was low.
- R10: A synchronous active-high reset clears the configuration, the latch, the mode bit and every output.
- R11: `rd_data` is the register at `rd_addr` one cycle later. Address 4 returns the live pin detects, and unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPIN | Pin levels, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Registered read data |
| pin_det_o | output | NPIN | Live per-pin detects |
| latch_det_o | output | 1 | Latched-detect signal |
| port_det_o | output | 1 | Port-level detect |
| port_evt_o | output | 1 | One-cycle event on port detect rising |

## Verification
A clear write to the latch and a pin detect that is high, or that is rising, can fall on the same cycle. The block must then keep the latch bit set and still produce the one-cycle low on the latched-detect signal. The bench provokes this case by raising a pin at several offsets relative to a clear of the same bit, and again in a random phase that mixes pin toggles with clears. A behavioural model computes the latch word, the latched-detect signal, the port detect and the event for every cycle, and each cycle these are compared with the read port and the outputs.

// File: rtl/pin_sense_pkg.sv
package pin_sense_pkg;

  typedef enum logic [1:0] {
    SNS_OFF  = 2'b00,
    SNS_RSVD = 2'b01,
    SNS_HIGH = 2'b10,
    SNS_LOW  = 2'b11
  } sense_e;

  // Evaluate a sense field against a pin level
  function automatic logic sense_hit(input logic [1:0] field, input logic level);
    logic hit;
    case (sense_e'(field))
      SNS_HIGH: hit = level;
      SNS_LOW:  hit = ~level;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/sense_regs.sv
module sense_regs #(
  parameter int NPIN      = 32,
  parameter int DW        = 32,
  parameter int AW        = 3,
  parameter int CFG_WORDS = 2,
  parameter int MODE_ADDR = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  output logic [CFG_WORDS*DW-1:0] cfg_words_o,
  output logic [2*NPIN-1:0]       cfg_flat_o,
  output logic                    mode_o
);

  logic [DW-1:0] cfg_q [CFG_WORDS];
  logic          mode_q;

  for (genvar w = 0; w < CFG_WORDS; w++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst)
        cfg_q[w] <= '0;
      else if (wr_en && wr_addr == AW'(w))
        cfg_q[w] <= wr_data;
    end
    assign cfg_words_o[w*DW +: DW] = cfg_q[w];
  end

  always_ff @(posedge clk) begin
    if (rst)
      mode_q <= 1'b0;
    else if (wr_en && wr_addr == AW'(MODE_ADDR))
      mode_q <= wr_data[0];
  end

  assign cfg_flat_o = cfg_words_o[2*NPIN-1:0];
  assign mode_o     = mode_q;

endmodule

// File: rtl/sense_eval.sv
module sense_eval #(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2*NPIN-1:0] cfg_flat_i,
  input  logic [NPIN-1:0]   pin_i,
  output logic [NPIN-1:0]   det_o
);
  import pin_sense_pkg::*;

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    logic det_q;
    always_ff @(posedge clk) begin
      if (rst)
        det_q <= 1'b0;
      else
        det_q <= sense_hit(cfg_flat_i[2*n +: 2], pin_i[n]);
    end
    assign det_o[n] = det_q;
  end

endmodule

// File: rtl/latch_bank.sv
module latch_bank #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] det_i,
  input  logic            clr_evt_i,
  input  logic [NPIN-1:0] clr_mask_i,
  output logic [NPIN-1:0] latch_o,
  output logic            ldet_o
);

  logic [NPIN-1:0] latch_q;
  logic [NPIN-1:0] latch_d;
  logic            ldet_q;

  // A high detect both sets the bit and overrides any clear of it
  always_comb begin
    latch_d = det_i | (latch_q & ~clr_mask_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      ldet_q  <= 1'b0;
    end else begin
      latch_q <= latch_d;
      ldet_q  <= clr_evt_i ? 1'b0 : (|latch_q);
    end
  end

  assign latch_o = latch_q;
  assign ldet_o  = ldet_q;

endmodule

// File: rtl/port_detect.sv
module port_detect (
  input  logic clk,
  input  logic rst,
  input  logic mode_i,
  input  logic ldet_i,
  input  logic any_det_i,
  output logic port_o,
  output logic evt_o
);

  logic port_q;
  logic evt_q;
  logic sel;

  always_comb begin
    sel = mode_i ? ldet_i : any_det_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      port_q <= sel;
      evt_q  <= sel & ~port_q;
    end
  end

  assign port_o = port_q;
  assign evt_o  = evt_q;

endmodule

// File: rtl/pin_sense_latch.sv
module pin_sense_latch #(
  parameter int NPIN = 32,
  parameter int DW   = 32,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_i,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic [NPIN-1:0] pin_det_o,
  output logic            latch_det_o,
  output logic            port_det_o,
  output logic            port_evt_o
);

  localparam int CFG_WORDS  = (2*NPIN + DW - 1) / DW;
  localparam int LATCH_ADDR = CFG_WORDS;
  localparam int MODE_ADDR  = CFG_WORDS + 1;
  localparam int LIVE_ADDR  = CFG_WORDS + 2;

  logic [CFG_WORDS*DW-1:0] cfg_words_w;
  logic [2*NPIN-1:0]       cfg_flat_w;
  logic                    mode_w;
  logic [NPIN-1:0]         det_w;
  logic [NPIN-1:0]         latch_w;
  logic                    ldet_w;
  logic                    clr_evt_w;
  logic [NPIN-1:0]         clr_mask_w;
  logic [DW-1:0]           rd_mux;
  logic [DW-1:0]           rd_q;

  sense_regs #(
    .NPIN(NPIN), .DW(DW), .AW(AW), .CFG_WORDS(CFG_WORDS), .MODE_ADDR(MODE_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_words_o(cfg_words_w), .cfg_flat_o(cfg_flat_w), .mode_o(mode_w)
  );

  sense_eval #(.NPIN(NPIN)) u_eval (
    .clk(clk), .rst(rst), .cfg_flat_i(cfg_flat_w), .pin_i(pin_i), .det_o(det_w)
  );

  assign clr_evt_w  = wr_en && (wr_addr == AW'(LATCH_ADDR));
  assign clr_mask_w = clr_evt_w ? wr_data[NPIN-1:0] : '0;

  latch_bank #(.NPIN(NPIN)) u_latch (
    .clk(clk), .rst(rst), .det_i(det_w), .clr_evt_i(clr_evt_w),
    .clr_mask_i(clr_mask_w), .latch_o(latch_w), .ldet_o(ldet_w)
  );

  port_detect u_port (
    .clk(clk), .rst(rst), .mode_i(mode_w), .ldet_i(ldet_w), .any_det_i(|det_w),
    .port_o(port_det_o), .evt_o(port_evt_o)
  );

  // Registered read port
  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < CFG_WORDS; w++) begin
      if (rd_addr == AW'(w))
        rd_mux = cfg_words_w[w*DW +: DW];
    end
    if (rd_addr == AW'(LATCH_ADDR))
      rd_mux[NPIN-1:0] = latch_w;
    if (rd_addr == AW'(MODE_ADDR))
      rd_mux[0] = mode_w;
    if (rd_addr == AW'(LIVE_ADDR))
      rd_mux[NPIN-1:0] = det_w;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_q <= '0;
    else
      rd_q <= rd_mux;
  end

  assign rd_data     = rd_q;
  assign pin_det_o   = det_w;
  assign latch_det_o = ldet_w;

endmodule

// File: rtl/pin_sense_latch_chk.sv
module pin_sense_latch_chk #(
  parameter int NPIN       = 32,
  parameter int DW         = 32,
  parameter int AW         = 3,
  parameter int LATCH_ADDR = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [DW-1:0]   wr_data,
  input logic [NPIN-1:0] pin_det,
  input logic [NPIN-1:0] latch_q,
  input logic            mode,
  input logic            ldet,
  input logic            port_det,
  input logic            port_evt
);

  logic            clr_hit;
  logic [NPIN-1:0] clr_m;
  assign clr_hit = wr_en && (wr_addr == AW'(LATCH_ADDR));
  assign clr_m   = clr_hit ? wr_data[NPIN-1:0] : '0;

  // R2
  latch_follows_det_chk: assert property (@(posedge clk) disable iff (rst)
    ((latch_q & $past(pin_det)) == $past(pin_det)));

  // R4
  clear_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(latch_q) & ~latch_q & ~$past(clr_m)) == '0));

  // R4
  clear_blocked_when_det_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(latch_q) & ~latch_q & $past(pin_det)) == '0));

  // R6
  ldet_low_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_hit |=> !ldet);

  // R5
  ldet_tracks_latch_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(clr_hit) |-> (ldet == (|$past(latch_q))));

  // R7
  port_source_chk: assert property (@(posedge clk) disable iff (rst)
    port_det == ($past(mode) ? $past(ldet) : (|$past(pin_det))));

  // R8
  event_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    port_evt == (port_det && !$past(port_det)));

endmodule

bind pin_sense_latch pin_sense_latch_chk #(
  .NPIN(NPIN), .DW(DW), .AW(AW), .LATCH_ADDR(LATCH_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pin_det(det_w), .latch_q(latch_w), .mode(mode_w), .ldet(ldet_w),
  .port_det(port_det_o), .port_evt(port_evt_o)
);

// File: tb/sim_pin_sense_latch.sv
`timescale 1ns/1ps
module sim_pin_sense_latch;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_i = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd2;
  logic [31:0] rd_data;
  logic [31:0] pin_det_o;
  logic        latch_det_o, port_det_o, port_evt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit started = 1'b0;

  always #4 clk = ~clk;

  pin_sense_latch #(.NPIN(32), .DW(32), .AW(3)) u0 (
    .clk(clk), .rst(rst), .pin_i(pin_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pin_det_o(pin_det_o), .latch_det_o(latch_det_o),
    .port_det_o(port_det_o), .port_evt_o(port_evt_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_cfg [2];
  logic [31:0] m_det, m_latch, m_rd;
  bit          m_mode, m_ldet, m_port, m_evt;

  initial begin
    m_cfg[0] = '0; m_cfg[1] = '0;
    m_det = '0; m_latch = '0; m_rd = '0;
    m_mode = 0; m_ldet = 0; m_port = 0; m_evt = 0;
  end

  always @(posedge clk) begin : model
    logic [31:0] nd, nl, nr, clr;
    bit sel;
    started = 1'b1;
    if (rst) begin
      m_cfg[0] = '0; m_cfg[1] = '0;
      m_det = '0; m_latch = '0; m_rd = '0;
      m_mode = 0; m_ldet = 0; m_port = 0; m_evt = 0;
    end else begin
      case (rd_addr)
        3'd0: nr = m_cfg[0];
        3'd1: nr = m_cfg[1];
        3'd2: nr = m_latch;
        3'd3: nr = {31'd0, m_mode};
        3'd4: nr = m_det;
        default: nr = '0;
      endcase
      for (int n = 0; n < 32; n++) begin
        int f;
        f = int'((m_cfg[n/16] >> (2*(n%16))) & 32'd3);
        if (f == 2)      nd[n] = pin_i[n];
        else if (f == 3) nd[n] = !pin_i[n];
        else             nd[n] = 1'b0;
      end
      clr = (wr_en && wr_addr == 3'd2) ? wr_data : '0;
      nl  = m_det | (m_latch & ~clr);
      sel = m_mode ? m_ldet : (m_det != 0);
      m_evt   = sel && !m_port;
      m_port  = sel;
      m_ldet  = (wr_en && wr_addr == 3'd2) ? 1'b0 : (m_latch != 0);
      m_latch = nl;
      m_det   = nd;
      m_rd    = nr;
      if (wr_en && wr_addr == 3'd0) m_cfg[0] = wr_data;
      if (wr_en && wr_addr == 3'd1) m_cfg[1] = wr_data;
      if (wr_en && wr_addr == 3'd3) m_mode = wr_data[0];
    end
  end

  // Compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R1 R9 pin_det", pin_det_o, m_det);
      chk("R3 R4 R11 rd_data", rd_data, m_rd);
      chk("R5 R6 latch_det", {31'd0, latch_det_o}, {31'd0, m_ldet});
      chk("R7 port_det", {31'd0, port_det_o}, {31'd0, m_port});
      chk("R8 port_evt", {31'd0, port_evt_o}, {31'd0, m_evt});
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    // R10: everything zero out of reset
    chk("R10 rd_data", rd_data, 32'd0);
    chk("R10 outputs", {28'd0, latch_det_o, port_det_o, port_evt_o, |pin_det_o}, 32'd0);

    // R1: pin 3 sense high, pin 5 reserved code 01
    wr(3'd0, 32'h0000_0480);
    pin_i[5] = 1'b1;
    tick(3);
    chk("R1 reserved code", {31'd0, pin_det_o[5]}, 32'd0);
    // R2 R3: short pulse on pin 3
    pin_i[3] = 1'b1;
    tick(2);
    pin_i[3] = 1'b0;
    tick(5);
    chk("R3 latch holds", rd_data, 32'h0000_0008);

    // R9: enable sense-low on pin 20 while pin is low
    wr(3'd1, 32'h0000_0300);
    tick();
    chk("R9 immediate detect", {31'd0, pin_det_o[20]}, 32'd1);
    tick();
    chk("R9 port event", {30'd0, port_det_o, port_evt_o}, 32'd3);

    // R4: clear blocked while detect high
    wr(3'd2, 32'h0010_0000);
    tick(2);
    chk("R4 blocked clear", rd_data, 32'h0010_0008);

    // R7: select latched-detect source, release pin 20
    wr(3'd3, 32'd1);
    pin_i[20] = 1'b1;
    tick(3);
    // R6: clear bit 20 only, bit 3 remains
    wr(3'd2, 32'h0010_0000);
    chk("R6 low after clear", {31'd0, latch_det_o}, 32'd0);
    tick();
    chk("R6 high again", {31'd0, latch_det_o}, 32'd1);
    tick(3);
    // R5: clear everything
    wr(3'd2, 32'hFFFF_FFFF);
    tick(3);
    chk("R5 all cleared", {31'd0, latch_det_o}, 32'd0);

    // Clear racing a rising detect at several offsets
    for (int off = 0; off < 4; off++) begin
      pin_i[3] = 1'b1;
      tick(off);
      wr(3'd2, 32'h0000_0008);
      pin_i[3] = 1'b0;
      tick(3);
      wr(3'd2, 32'h0000_0008);
      tick(3);
    end

    // R11: mode readback, live detects, unmapped address
    rd_addr = 3'd3; tick(2);
    chk("R11 mode read", rd_data, 32'd1);
    rd_addr = 3'd7; tick(2);
    chk("R11 unmapped", rd_data, 32'd0);
    rd_addr = 3'd4; tick(2);

    // Random mix of pins, clears, configuration and mode
    wr(3'd0, 32'hE4E4_E4E4);
    wr(3'd1, 32'hB1B1_B1B1);
    rd_addr = 3'd2;
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom_range(0, 19));
      if ($urandom_range(0, 3) == 0) pin_i = $urandom;
      if (r == 0)       wr(3'd2, $urandom);
      else if (r == 1)  wr(3'd3, {31'd0, 1'($urandom_range(0, 1))});
      else if (r == 2)  wr(3'd0, $urandom);
      else if (r == 3)  rd_addr = 3'($urandom_range(0, 7));
      else              tick();
    end
    tick(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule